// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer with Address-Space Tags

This block keeps a small set of cached page-table mappings and translates a virtual page number into a physical frame number in the same cycle as the request. Every slot is compared in parallel against the requested page number and address-space identifier. The page offset is never translated: it is appended unchanged to the frame number to form the physical address. Each slot holds a read-permission bit and a write-permission bit, and every lookup is checked against them. A lookup that matches but lacks permission reports a fault instead of a hit.

Slots are loaded through a refill port, driven for example by a table walker or by miss-handling software. The slot to overwrite is chosen in this order: a slot already holding the same page and identifier, then the lowest-numbered empty slot, then a slot picked by a free-running LFSR. Two flush inputs clear slots in one cycle. One clears every slot. The other clears only the slots tagged with a given identifier.

Top module: `tlb_fa`

## Requirements
- R1: After reset every slot is empty, so every lookup reports neither hit nor fault.
- R2: A lookup hits only when a valid slot matches both the requested page number and the requested address-space identifier. On a hit it returns that slot's frame number.
- R3: A lookup that matches a slot reports a fault, and not a hit, if it is a write (`lk_wr`=1) to a slot without write permission, or a read (`lk_wr`=0) to a slot without read permission. Hit and fault are never both high.
- R4: A refill whose page and identifier are already held overwrites that slot. No two valid slots ever match the same lookup, and later lookups return the new frame.
- R5: While any slot is empty, a refill fills an empty slot, so a run of distinct refills no longer than the depth keeps every mapping.
- R6: When all slots are valid, a refill of a new mapping replaces exactly one existing mapping, chosen pseudo-randomly. The new mapping hits afterwards.
- R7: A flush-all pulse (`fl_all`=1 for one cycle) empties every slot from the next cycle on.
- R8: A flush by identifier (`fl_asid_en`=1) empties exactly the slots whose identifier equals `fl_asid` and leaves all others intact.
- R9: While `lk_valid` is low, `lk_hit` and `lk_fault` stay low whatever the lookup fields hold.
- R10: The physical address `lk_pa` is `{frame, lk_off}` on a hit and zero otherwise, including on a fault.
- R11: A refill in the same cycle as a flush is applied after the flush, so the refilled mapping survives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lk_valid | input | 1 | Lookup request present |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| lk_asid | input | ASID_W | Address-space identifier of the request |
| lk_off | input | OFF_W | Page offset, passed through untranslated |
| lk_wr | input | 1 | 1 = write access, 0 = read access |
| lk_hit | output | 1 | Matching slot found and access permitted |
| lk_fault | output | 1 | Matching slot found but access not permitted |
| lk_pa | output | PPN_W+OFF_W | Physical address on a hit, zero otherwise |
| rf_valid | input | 1 | Write a mapping this cycle |
| rf_vpn | input | VPN_W | Page number of the new mapping |
| rf_asid | input | ASID_W | Identifier of the new mapping |
| rf_ppn | input | PPN_W | Frame number of the new mapping |
| rf_perm_rd | input | 1 | Read permitted for the new mapping |
| rf_perm_wr | input | 1 | Write permitted for the new mapping |
| fl_all | input | 1 | Empty every slot |
| fl_asid_en | input | 1 | Empty slots tagged with fl_asid |
| fl_asid | input | ASID_W | Identifier to flush |

## Verification
The assertions watch, on every cycle, that hit and fault never coincide, that no lookup matches more than one slot, that an idle request shows neither flag, that the address is zero without a hit, that a mapping just refilled is found on the next cycle, and that nothing is found right after a flush-all. Only the bench scenarios can show the choice of slot: that empty slots are filled before any eviction, that a full buffer loses exactly one old mapping per refill, and that a flush by identifier leaves the other identifiers untouched. Frame values and permission outcomes also depend on those scenarios.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

   typedef struct packed {
      logic rd;
      logic wr;
   } tlb_perm_t;

   // Galois feedback masks for maximal-length sequences of supported widths
   function automatic logic [31:0] lfsr_mask(input int w);
      case (w)
         8:       return 32'h0000_00B8;
         16:      return 32'h0000_B400;
         default: return 32'h8020_0003;
      endcase
   endfunction

endpackage

// File: rtl/tlb_lfsr.sv
module tlb_lfsr #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   output logic [W-1:0] state
);
   localparam logic [W-1:0] MASK = W'(tlb_pkg::lfsr_mask(W));

   if (W != 8 && W != 16 && W != 32) begin : g_bad_w
      $error("tlb_lfsr: W must be 8, 16 or 32");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         state <= W'(1);
      else if (state[0])
         state <= (state >> 1) ^ MASK;
      else
         state <= state >> 1;
   end
endmodule

// File: rtl/tlb_cam.sv
module tlb_cam #(
   parameter int ENTRIES = 8,
   parameter int VPN_W   = 20,
   parameter int ASID_W  = 8
) (
   input  logic [ENTRIES-1:0]             valid,
   input  logic [ENTRIES-1:0][VPN_W-1:0]  tag_vpn,
   input  logic [ENTRIES-1:0][ASID_W-1:0] tag_asid,
   input  logic [VPN_W-1:0]               key_vpn,
   input  logic [ASID_W-1:0]              key_asid,
   output logic [ENTRIES-1:0]             match
);
   for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
      assign match[i] = valid[i] && (tag_vpn[i] == key_vpn) && (tag_asid[i] == key_asid);
   end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
   parameter int ENTRIES = 8,
   parameter int IDX_W   = 3
) (
   input  logic [ENTRIES-1:0] valid,
   input  logic [ENTRIES-1:0] same_tag,
   input  logic [IDX_W-1:0]   rnd_idx,
   output logic [IDX_W-1:0]   victim
);
   logic [IDX_W-1:0] same_idx;
   logic [IDX_W-1:0] free_idx;

   always_comb begin
      same_idx = '0;
      free_idx = '0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (same_tag[i]) same_idx = IDX_W'(i);
         if (!valid[i])   free_idx = IDX_W'(i);
      end
   end

   always_comb begin
      if (|same_tag)
         victim = same_idx;
      else if (!(&valid))
         victim = free_idx;
      else
         victim = rnd_idx;
   end
endmodule

// File: rtl/tlb_fa.sv
module tlb_fa #(
   parameter int ENTRIES = 8,
   parameter int VPN_W   = 20,
   parameter int PPN_W   = 20,
   parameter int ASID_W  = 8,
   parameter int OFF_W   = 12,
   parameter int LFSR_W  = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    lk_valid,
   input  logic [VPN_W-1:0]        lk_vpn,
   input  logic [ASID_W-1:0]       lk_asid,
   input  logic [OFF_W-1:0]        lk_off,
   input  logic                    lk_wr,
   output logic                    lk_hit,
   output logic                    lk_fault,
   output logic [PPN_W+OFF_W-1:0]  lk_pa,
   input  logic                    rf_valid,
   input  logic [VPN_W-1:0]        rf_vpn,
   input  logic [ASID_W-1:0]       rf_asid,
   input  logic [PPN_W-1:0]        rf_ppn,
   input  logic                    rf_perm_rd,
   input  logic                    rf_perm_wr,
   input  logic                    fl_all,
   input  logic                    fl_asid_en,
   input  logic [ASID_W-1:0]       fl_asid
);
   import tlb_pkg::*;

   localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
   localparam int PA_W  = PPN_W + OFF_W;

   if ((ENTRIES & (ENTRIES - 1)) != 0 || ENTRIES < 2) begin : g_bad_depth
      $error("tlb_fa: ENTRIES must be a power of two, at least 2");
   end
   if (LFSR_W < IDX_W) begin : g_bad_lfsr
      $error("tlb_fa: LFSR_W narrower than slot index");
   end

   logic [ENTRIES-1:0]             slot_vld;
   logic [ENTRIES-1:0][VPN_W-1:0]  slot_vpn;
   logic [ENTRIES-1:0][ASID_W-1:0] slot_asid;
   logic [ENTRIES-1:0][PPN_W-1:0]  slot_ppn;
   tlb_perm_t [ENTRIES-1:0]        slot_perm;

   logic [ENTRIES-1:0] lk_match;
   logic [ENTRIES-1:0] rf_match;
   logic [LFSR_W-1:0]  rnd;
   logic [IDX_W-1:0]   victim;

   tlb_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) i_lk_cam (
      .valid(slot_vld), .tag_vpn(slot_vpn), .tag_asid(slot_asid),
      .key_vpn(lk_vpn), .key_asid(lk_asid), .match(lk_match));

   tlb_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) i_rf_cam (
      .valid(slot_vld), .tag_vpn(slot_vpn), .tag_asid(slot_asid),
      .key_vpn(rf_vpn), .key_asid(rf_asid), .match(rf_match));

   tlb_lfsr #(.W(LFSR_W)) i_lfsr (.clk(clk), .rst_n(rst_n), .state(rnd));

   tlb_victim #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) i_victim (
      .valid(slot_vld), .same_tag(rf_match), .rnd_idx(rnd[IDX_W-1:0]),
      .victim(victim));

   // Lookup datapath: one-hot mux of the matching slot
   logic [PPN_W-1:0] sel_ppn;
   tlb_perm_t        sel_perm;
   logic             any_match;
   logic             allowed;

   always_comb begin
      sel_ppn  = '0;
      sel_perm = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (lk_match[i]) begin
            sel_ppn  = sel_ppn | slot_ppn[i];
            sel_perm = sel_perm | slot_perm[i];
         end
      end
   end

   assign any_match = lk_valid && (|lk_match);
   assign allowed   = lk_wr ? sel_perm.wr : sel_perm.rd;
   assign lk_hit    = any_match && allowed;
   assign lk_fault  = any_match && !allowed;
   assign lk_pa     = lk_hit ? {sel_ppn, lk_off} : PA_W'(0);

   // Valid bits: flush first, refill afterwards so it survives
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot_vld <= '0;
      end else begin
         for (int i = 0; i < ENTRIES; i++) begin
            if (fl_all || (fl_asid_en && slot_asid[i] == fl_asid))
               slot_vld[i] <= 1'b0;
         end
         if (rf_valid)
            slot_vld[victim] <= 1'b1;
      end
   end

   // Slot payload needs no reset: it is qualified by the valid bit
   always_ff @(posedge clk) begin
      if (rf_valid) begin
         slot_vpn[victim]     <= rf_vpn;
         slot_asid[victim]    <= rf_asid;
         slot_ppn[victim]     <= rf_ppn;
         slot_perm[victim].rd <= rf_perm_rd;
         slot_perm[victim].wr <= rf_perm_wr;
      end
   end
endmodule

// File: rtl/tlb_fa_chk.sv
module tlb_fa_chk #(
   parameter int ENTRIES = 8,
   parameter int VPN_W   = 20,
   parameter int ASID_W  = 8,
   parameter int PA_W    = 32
) (
   input logic               clk,
   input logic               rst_n,
   input logic               lk_valid,
   input logic [VPN_W-1:0]   lk_vpn,
   input logic [ASID_W-1:0]  lk_asid,
   input logic               lk_hit,
   input logic               lk_fault,
   input logic [PA_W-1:0]    lk_pa,
   input logic               rf_valid,
   input logic [VPN_W-1:0]   rf_vpn,
   input logic [ASID_W-1:0]  rf_asid,
   input logic               fl_all,
   input logic [ENTRIES-1:0] lk_match
);
   // R3
   hit_fault_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(lk_hit && lk_fault));

   // R4
   single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(lk_match) <= 1);

   // R9
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid |-> !(lk_hit || lk_fault));

   // R10
   pa_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_hit |-> lk_pa == '0);

   // R7
   flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fl_all && !rf_valid) |=> !(lk_hit || lk_fault));

   // R11
   refill_found_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rf_valid |=> (!(lk_valid && lk_vpn == $past(rf_vpn) && lk_asid == $past(rf_asid))
                    || lk_hit || lk_fault));
endmodule

bind tlb_fa tlb_fa_chk #(
   .ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W), .PA_W(PPN_W + OFF_W)
) i_chk (
   .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vpn(lk_vpn),
   .lk_asid(lk_asid), .lk_hit(lk_hit), .lk_fault(lk_fault), .lk_pa(lk_pa),
   .rf_valid(rf_valid), .rf_vpn(rf_vpn), .rf_asid(rf_asid), .fl_all(fl_all),
   .lk_match(lk_match)
);

// File: tb/test_tlb_fa.sv
module test_tlb_fa;
   localparam int ENTRIES = 8;
   localparam int VPN_W = 20, PPN_W = 20, ASID_W = 8, OFF_W = 12;
   localparam int PA_W = PPN_W + OFF_W;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic lk_valid = 0, lk_wr = 0;
   logic [VPN_W-1:0] lk_vpn = '0;
   logic [ASID_W-1:0] lk_asid = '0;
   logic [OFF_W-1:0] lk_off = '0;
   logic lk_hit, lk_fault;
   logic [PA_W-1:0] lk_pa;
   logic rf_valid = 0, rf_perm_rd = 0, rf_perm_wr = 0;
   logic [VPN_W-1:0] rf_vpn = '0;
   logic [ASID_W-1:0] rf_asid = '0;
   logic [PPN_W-1:0] rf_ppn = '0;
   logic fl_all = 0, fl_asid_en = 0;
   logic [ASID_W-1:0] fl_asid = '0;

   always #2 clk = ~clk;

   tlb_fa i_tlb_fa (.*);

   int n_chk = 0, n_err = 0;
   bit done = 0;

   bit        q_hit[$];
   bit        q_fault[$];
   logic [PA_W-1:0] q_pa[$];
   string     q_tag[$];

   task automatic check(input string tag, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // Monitor: compares outputs with queued expectations while a lookup is live
   always @(posedge clk) begin
      if (q_tag.size() > 0 && lk_valid) begin
         automatic string t = q_tag.pop_front();
         automatic bit eh = q_hit.pop_front();
         automatic bit ef = q_fault.pop_front();
         automatic logic [PA_W-1:0] ep = q_pa.pop_front();
         check({t, " hit"}, lk_hit, eh);
         check({t, " fault"}, lk_fault, ef);
         check({t, " pa"}, lk_pa, ep);
      end
   end

   // Driver: presents a lookup and pushes what the monitor must see
   task automatic look(input string tag, input int vpn, input int asid, input bit wr,
                       input int off, input bit eh, input bit ef, input logic [PA_W-1:0] ep);
      @(negedge clk);
      lk_valid = 1; lk_vpn = VPN_W'(vpn); lk_asid = ASID_W'(asid);
      lk_wr = wr; lk_off = OFF_W'(off);
      q_hit.push_back(eh); q_fault.push_back(ef); q_pa.push_back(ep); q_tag.push_back(tag);
      @(negedge clk);
      lk_valid = 0;
   endtask

   // Probe: returns whether a read lookup hits, without a queued expectation
   task automatic probe(input int vpn, input int asid, output bit h);
      @(negedge clk);
      lk_valid = 1; lk_vpn = VPN_W'(vpn); lk_asid = ASID_W'(asid); lk_wr = 0;
      #1 h = lk_hit;
      @(negedge clk);
      lk_valid = 0;
   endtask

   task automatic refill(input int vpn, input int asid, input int ppn, input bit rd, input bit wr);
      @(negedge clk);
      rf_valid = 1; rf_vpn = VPN_W'(vpn); rf_asid = ASID_W'(asid);
      rf_ppn = PPN_W'(ppn); rf_perm_rd = rd; rf_perm_wr = wr;
      @(negedge clk);
      rf_valid = 0;
   endtask

   function automatic logic [PA_W-1:0] pa(input int ppn, input int off);
      return {PPN_W'(ppn), OFF_W'(off)};
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_err++; n_chk++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      bit h;
      int cnt;
      int a1_before, a1_after;
      repeat (3) @(negedge clk);
      rst_n = 1;

      // R1: empty after reset
      look("R1 reset miss", 5, 1, 0, 0, 0, 0, '0);

      // R2: match on page and identifier returns the frame
      refill(5, 1, 'hABCDE, 1, 1);
      look("R2 hit", 5, 1, 0, 'h123, 1, 0, pa('hABCDE, 'h123));
      look("R2 asid differs", 5, 2, 0, 'h123, 0, 0, '0);
      look("R10 miss pa zero", 6, 1, 1, 'h7FF, 0, 0, '0);

      // R3: permissions
      refill(7, 1, 'h11111, 1, 0);
      look("R3 write denied", 7, 1, 1, 'h10, 0, 1, '0);
      look("R3 read ok", 7, 1, 0, 'h10, 1, 0, pa('h11111, 'h10));
      refill(8, 1, 'h33333, 0, 1);
      look("R3 read denied", 8, 1, 0, 'h20, 0, 1, '0);

      // R4: same tag overwrites
      refill(5, 1, 'h22222, 1, 1);
      look("R4 replaced frame", 5, 1, 1, 'hFFF, 1, 0, pa('h22222, 'hFFF));

      // R9: idle request shows nothing
      @(negedge clk);
      lk_valid = 0; lk_vpn = 5; lk_asid = 1;
      #1 check("R9 idle hit", lk_hit, 0);
      check("R9 idle fault", lk_fault, 0);

      // R5: fill the remaining five slots, all mappings kept
      for (int i = 0; i < 5; i++) refill('h100 + i, 3, 'h40000 + i, 1, 1);
      cnt = 0;
      for (int i = 0; i < 5; i++) begin probe('h100 + i, 3, h); cnt += h; end
      probe(5, 1, h); cnt += h; probe(7, 1, h); cnt += h; probe(8, 1, h); cnt += h;
      check("R5 all kept (read hits; slot 8 lacks read)", cnt, 7);

      // R6: full buffer, one new mapping evicts exactly one
      refill('h200, 3, 'h55555, 1, 1);
      look("R6 new mapping", 'h200, 3, 0, 1, 1, 0, pa('h55555, 1));
      cnt = 0;
      for (int i = 0; i < 5; i++) begin probe('h100 + i, 3, h); cnt += h; end
      probe(5, 1, h); cnt += h; probe(7, 1, h); cnt += h;
      a1_before = 0;
      probe(5, 1, h); a1_before += h; probe(7, 1, h); a1_before += h;
      // slot for vpn 8 is write-only; count it with a write lookup
      @(negedge clk);
      lk_valid = 1; lk_vpn = 8; lk_asid = 1; lk_wr = 1;
      #1 cnt += (lk_hit ? 1 : 0); a1_before += (lk_hit ? 1 : 0);
      @(negedge clk); lk_valid = 0;
      check("R6 one mapping lost", cnt, 7);

      // R8: flush identifier 3 only
      @(negedge clk); fl_asid_en = 1; fl_asid = 3;
      @(negedge clk); fl_asid_en = 0;
      cnt = 0;
      for (int i = 0; i < 5; i++) begin probe('h100 + i, 3, h); cnt += h; end
      probe('h200, 3, h); cnt += h;
      check("R8 flushed id gone", cnt, 0);
      a1_after = 0;
      probe(5, 1, h); a1_after += h; probe(7, 1, h); a1_after += h;
      @(negedge clk);
      lk_valid = 1; lk_vpn = 8; lk_asid = 1; lk_wr = 1;
      #1 a1_after += (lk_hit ? 1 : 0);
      @(negedge clk); lk_valid = 0;
      check("R8 other ids kept", a1_after, a1_before);

      // R11: refill together with flush-all survives; R7 the rest is gone
      @(negedge clk);
      fl_all = 1; rf_valid = 1; rf_vpn = 9; rf_asid = 4; rf_ppn = 'h77777;
      rf_perm_rd = 1; rf_perm_wr = 1;
      @(negedge clk); fl_all = 0; rf_valid = 0;
      look("R11 refill survives flush", 9, 4, 0, 'h42, 1, 0, pa('h77777, 'h42));
      look("R7 old mapping flushed", 7, 1, 0, 0, 0, 0, '0);

      // R7: flush-all alone
      @(negedge clk); fl_all = 1;
      @(negedge clk); fl_all = 0;
      look("R7 all empty", 9, 4, 0, 0, 0, 0, '0);

      repeat (3) @(negedge clk);
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule